// File: doc/BRIEF.md
# SPI Target Shared-Buffer Peripheral

This block is the target end of a serial host link that runs in SPI mode 0. While chip select is low, every byte the host clocks in lands in a circular input buffer, and in the same transfer the block returns bytes taken from an output buffer. A single byte pointer indexes both buffers. A transaction therefore reads back, at each position, whatever firmware staged in the output buffer at that index. Firmware stages and collects data through a simple register-style port. That port maps both buffers and a small set of control, event and pointer registers.

The serial inputs pass through two-flop synchronisers, and all edge detection happens in the system clock domain. For that reason SCK must run slower than a quarter of the system clock. Sticky event flags mark chip-select edges, the pointer entering the upper half of the buffer, the pointer passing the last entry, and a programmable count of bytes received since chip select fell. The flags feed one masked interrupt.

Top module: `spi_tgt_buf`

## Requirements
- R1: Firmware reads and writes the two 128-entry buffers through the register port. Addresses 0x100+i select input entry i and 0x180+i select output entry i. Addresses 0x000 to 0x005 are the control registers: CONFIG (0), EVENTS (1), EVENT_MASK (2), POINTER (3), STATUS (4) and LEVEL (5).
- R2: Bits travel MSB first. MOSI is sampled on rising SCK. MISO changes only on falling SCK, or on chip-select fall, when the first bit of a transfer is presented.
- R3: The byte returned for each position is the output-buffer entry at the current pointer. The pointer advances by one for every 8 received bits.
- R4: With CONFIG bit1 (wrap) set, the pointer returns to 0 after entry 127. With wrap clear, it stays at 127 once that entry is written, and further received bytes are discarded.
- R5: EVENTS bit2 (half) is set when a byte is written at entry 63. EVENTS bit3 (full) is set when a byte is written at entry 127.
- R6: EVENTS bit4 (level) is set when the count of bytes received since chip select fell reaches LEVEL bits[6:0]. The reset value of that threshold is 8. LEVEL bit7 set disables this event.
- R7: A chip-select fall sets EVENTS bit0 and a chip-select rise sets EVENTS bit1. This holds even when no SCK pulse occurred in between.
- R8: Writing 1 to an EVENTS bit clears it and writing 0 leaves it. The irq output is high exactly when some EVENTS bit is set whose EVENT_MASK bit is set.
- R9: While CONFIG bit0 (unit enable) is clear, the pointer, all EVENTS bits and the bit and byte counters are held at zero, and serial activity has no effect.
- R10: STATUS bit0 and the busy output read 1 while chip select is low.
- R11: Received bytes are written into the input buffer only while CONFIG bit2 (host write enable) is set. The pointer still advances when that bit is clear.
- R12: POINTER reads the current pointer, which changes only when a byte completes or the unit is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| csN | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| busy | output | 1 | Chip select currently asserted |
| irq | output | 1 | Masked OR of event flags |
| regAddr | input | 9 | Register-port address |
| regWe | input | 1 | Register-port write strobe |
| regWdata | input | 8 | Register-port write data |
| regRdata | output | 8 | Register-port read data (combinational) |

## Verification
A wrong pointer shows up within a single byte: MISO returns the wrong staged entry, and the POINTER readback drifts from a count of completed bytes. A bad bit counter misaligns the serial bytes, so the captured input-buffer contents differ on the first transfer. Wrong event logic shows up in the EVENTS readback right after the transaction that should or should not have set a flag. The bench sweeps the pointer across the half mark, across the wrap point and into the non-wrapping stop, and compares every buffer entry against an arithmetic model.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Strobes from the control section to the datapath
  typedef struct packed {
    logic clear;      // unit disabled: hold datapath state at zero
    logic csStart;    // chip select just fell
    logic sampleBit;  // rising SCK: take bitVal
    logic bitVal;     // synchronised MOSI
    logic byteDone;   // eighth bit of a byte taken this cycle
    logic loadTx;     // load transmit shifter from output buffer
    logic shiftTx;    // advance transmit shifter one bit
  } dpStrobe_t;

  // Event flag positions
  localparam int EV_CS_FALL = 0;
  localparam int EV_CS_RISE = 1;
  localparam int EV_HALF    = 2;
  localparam int EV_FULL    = 3;
  localparam int EV_LEVEL   = 4;
  localparam int EV_NUM     = 5;

  // Control register offsets
  localparam logic [2:0] REG_CONFIG = 3'd0;
  localparam logic [2:0] REG_EVENTS = 3'd1;
  localparam logic [2:0] REG_MASK   = 3'd2;
  localparam logic [2:0] REG_PTR    = 3'd3;
  localparam logic [2:0] REG_STATUS = 3'd4;
  localparam logic [2:0] REG_LEVEL  = 3'd5;

  // Synchroniser lane positions
  localparam int SY_SCK  = 0;
  localparam int SY_CS   = 1;
  localparam int SY_MOSI = 2;

endpackage

// File: rtl/spi_tgt_ctrl.sv
module spi_tgt_ctrl
  import spi_tgt_pkg::*;
#(
  parameter int PTR_W       = 7,
  parameter int LVL_DEFAULT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic              ctrlWe,
  input  logic [2:0]        ctrlOff,
  input  logic [7:0]        ctrlWdata,
  input  logic              evHalf,
  input  logic              evFull,
  output dpStrobe_t         strb,
  output logic              unitEn,
  output logic              wrapEn,
  output logic              hostWrEn,
  output logic [EV_NUM-1:0] evStat,
  output logic [EV_NUM-1:0] evEn,
  output logic [PTR_W-1:0]  lvlThr,
  output logic              lvlDis,
  output logic              busy,
  output logic              irq
);

  logic [2:0] syncA, syncB;
  logic [1:0] prevB;
  logic       csActive, csFallDet, csRiseDet, sckRise, sckFall;
  logic [2:0] bitCnt;
  logic [PTR_W-1:0] byteCnt, cntNext;
  logic       cntFull, levelHit;
  logic [EV_NUM-1:0] evSet, evClr;
  logic       cfgWe, evClrWe, evEnWe, lvlWe;

  // Two-flop synchronisers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= 3'b010;
      syncB <= 3'b010;
      prevB <= 2'b10;
    end else begin
      syncA <= {mosiIn, csNIn, sckIn};
      syncB <= syncA;
      prevB <= syncB[1:0];
    end
  end

  always_comb begin
    csActive  = ~syncB[SY_CS];
    csFallDet = prevB[SY_CS] & ~syncB[SY_CS];
    csRiseDet = ~prevB[SY_CS] & syncB[SY_CS];
    sckRise   = csActive & syncB[SY_SCK] & ~prevB[SY_SCK];
    sckFall   = csActive & ~syncB[SY_SCK] & prevB[SY_SCK];
  end

  always_comb begin
    strb.clear     = ~unitEn;
    strb.csStart   = unitEn & csFallDet;
    strb.sampleBit = unitEn & sckRise;
    strb.bitVal    = syncB[SY_MOSI];
    strb.byteDone  = unitEn & sckRise & (bitCnt == 3'd7);
    strb.loadTx    = (unitEn & csFallDet) | (unitEn & sckFall & (bitCnt == 3'd0));
    strb.shiftTx   = unitEn & sckFall & (bitCnt != 3'd0);
  end

  // Bit and byte counters for the current transaction
  always_ff @(posedge clk) begin
    if (rst || strb.clear || strb.csStart) begin
      bitCnt  <= '0;
      byteCnt <= '0;
    end else if (strb.sampleBit) begin
      bitCnt <= bitCnt + 3'd1;
      if (strb.byteDone && !cntFull) byteCnt <= cntNext;
    end
  end

  always_comb begin
    cntFull  = &byteCnt;
    cntNext  = byteCnt + 1'b1;
    levelHit = strb.byteDone & ~lvlDis & ~cntFull & (lvlThr != '0) & (cntNext == lvlThr);
  end

  // Register decode
  always_comb begin
    cfgWe   = ctrlWe && (ctrlOff == REG_CONFIG);
    evClrWe = ctrlWe && (ctrlOff == REG_EVENTS);
    evEnWe  = ctrlWe && (ctrlOff == REG_MASK);
    lvlWe   = ctrlWe && (ctrlOff == REG_LEVEL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      unitEn   <= 1'b0;
      wrapEn   <= 1'b0;
      hostWrEn <= 1'b0;
      evEn     <= '0;
      lvlThr   <= PTR_W'(LVL_DEFAULT);
      lvlDis   <= 1'b0;
    end else begin
      if (cfgWe) begin
        unitEn   <= ctrlWdata[0];
        wrapEn   <= ctrlWdata[1];
        hostWrEn <= ctrlWdata[2];
      end
      if (evEnWe) evEn <= ctrlWdata[EV_NUM-1:0];
      if (lvlWe) begin
        lvlThr <= ctrlWdata[PTR_W-1:0];
        lvlDis <= ctrlWdata[7];
      end
    end
  end

  // Sticky event flags, write-one-to-clear, set wins over clear
  always_comb begin
    evSet = '0;
    evSet[EV_CS_FALL] = unitEn & csFallDet;
    evSet[EV_CS_RISE] = unitEn & csRiseDet;
    evSet[EV_HALF]    = evHalf;
    evSet[EV_FULL]    = evFull;
    evSet[EV_LEVEL]   = levelHit;
    evClr = evClrWe ? ctrlWdata[EV_NUM-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || strb.clear) evStat <= '0;
    else                   evStat <= (evStat & ~evClr) | evSet;
  end

  assign busy = csActive;
  assign irq  = |(evStat & evEn);

  // R7: a freshly set rise flag means chip select is released
  a_r7_rise_not_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(evStat[EV_CS_RISE]) |-> !busy);

  // R9: disabling the unit empties the event register on the next cycle
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !unitEn |=> (evStat == '0));

  // R8: a flag only drops through a write of 1 or a disable
  for (genvar gi = 0; gi < EV_NUM; gi++) begin : g_w1c
    a_r8_fall_by_w1c: assert property (@(posedge clk) disable iff (rst)
      $fell(evStat[gi]) |-> ($past(evClrWe && ctrlWdata[gi]) || $past(!unitEn)));
  end

endmodule

// File: rtl/spi_tgt_dp.sv
module spi_tgt_dp
  import spi_tgt_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strb,
  input  logic             wrapEn,
  input  logic             hostWrEn,
  input  logic             fwIbWe,
  input  logic             fwObWe,
  input  logic [PTR_W-1:0] fwIdx,
  input  logic [7:0]       fwData,
  output logic [7:0]       ibRd,
  output logic [7:0]       obRd,
  output logic [PTR_W-1:0] ptr,
  output logic             miso,
  output logic             evHalf,
  output logic             evFull
);

  localparam int HALF = DEPTH / 2;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] HALF_IDX = PTR_W'(HALF - 1);

  logic [7:0] ibMem [DEPTH];
  logic [7:0] obMem [DEPTH];
  logic [7:0] rxShift, txShift, rxByte;
  logic       held, accept, hostWr;

  always_comb begin
    rxByte = {rxShift[6:0], strb.bitVal};
    accept = strb.byteDone & ~held;
    evHalf = accept & (ptr == HALF_IDX);
    evFull = accept & (ptr == LAST_IDX);
    hostWr = accept & hostWrEn;
  end

  // Input buffer: a completed host byte takes priority over firmware
  always_ff @(posedge clk) begin
    if (hostWr)      ibMem[ptr]   <= rxByte;
    else if (fwIbWe) ibMem[fwIdx] <= fwData;
  end

  always_ff @(posedge clk) begin
    if (fwObWe) obMem[fwIdx] <= fwData;
  end

  assign ibRd = ibMem[fwIdx];
  assign obRd = obMem[fwIdx];

  // Shared pointer and the two shifters
  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      ptr     <= '0;
      held    <= 1'b0;
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (strb.csStart)        rxShift <= '0;
      else if (strb.sampleBit) rxShift <= rxByte;
      if (accept) begin
        if (ptr == LAST_IDX) begin
          if (wrapEn) ptr  <= '0;
          else        held <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
      if (strb.loadTx)       txShift <= obMem[ptr];
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign miso = txShift[7];

  // R12: pointer moves only on an accepted byte or a disable
  a_r12_ptr_stable: assert property (@(posedge clk) disable iff (rst)
    (!accept && !strb.clear) |=> $stable(ptr));

  // R4: each accepted byte steps the pointer by one, wraps, or stops
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (accept && !strb.clear) |=> ((ptr == PTR_W'($past(ptr) + 1'b1)) || (ptr == '0) || held));

  // R5: the full event is followed by a wrap or a stop
  a_r5_full_then_wrap: assert property (@(posedge clk) disable iff (rst)
    evFull |=> ((ptr == '0) || held));

  // R2: MISO only moves when the control asks for a load or shift
  a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> $past(strb.loadTx || strb.shiftTx || strb.clear));

endmodule

// File: rtl/spi_tgt_buf.sv
module spi_tgt_buf
  import spi_tgt_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int LVL_DEFAULT = 8,
  parameter int PTR_W       = $clog2(DEPTH),
  parameter int ADDR_W      = PTR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso,
  output logic              busy,
  output logic              irq,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata
);

  dpStrobe_t         strb;
  logic              unitEn, wrapEn, hostWrEn, lvlDis, evHalf, evFull;
  logic [EV_NUM-1:0] evStat, evEn;
  logic [PTR_W-1:0]  lvlThr, ptr, fwIdx;
  logic [7:0]        ibRd, obRd;
  logic [1:0]        region;
  logic              ctrlSel, ctrlWe, fwIbWe, fwObWe;
  logic [2:0]        ctrlOff;

  always_comb begin
    region  = regAddr[ADDR_W-1 -: 2];
    fwIdx   = regAddr[PTR_W-1:0];
    ctrlOff = regAddr[2:0];
    ctrlSel = (region == 2'b00) && (regAddr[ADDR_W-3:3] == '0);
    ctrlWe  = regWe && ctrlSel;
    fwIbWe  = regWe && (region == 2'b10);
    fwObWe  = regWe && (region == 2'b11);
  end

  spi_tgt_ctrl #(.PTR_W(PTR_W), .LVL_DEFAULT(LVL_DEFAULT)) u_ctrl (
    .clk(clk), .rst(rst), .sckIn(sck), .csNIn(csN), .mosiIn(mosi),
    .ctrlWe(ctrlWe), .ctrlOff(ctrlOff), .ctrlWdata(regWdata),
    .evHalf(evHalf), .evFull(evFull), .strb(strb),
    .unitEn(unitEn), .wrapEn(wrapEn), .hostWrEn(hostWrEn),
    .evStat(evStat), .evEn(evEn), .lvlThr(lvlThr), .lvlDis(lvlDis),
    .busy(busy), .irq(irq)
  );

  spi_tgt_dp #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrapEn(wrapEn), .hostWrEn(hostWrEn),
    .fwIbWe(fwIbWe), .fwObWe(fwObWe), .fwIdx(fwIdx), .fwData(regWdata),
    .ibRd(ibRd), .obRd(obRd), .ptr(ptr), .miso(miso),
    .evHalf(evHalf), .evFull(evFull)
  );

  // Read multiplexer
  always_comb begin
    regRdata = '0;
    unique case (region)
      2'b10: regRdata = ibRd;
      2'b11: regRdata = obRd;
      2'b00: if (ctrlSel) begin
        unique case (ctrlOff)
          REG_CONFIG: regRdata = {5'b0, hostWrEn, wrapEn, unitEn};
          REG_EVENTS: regRdata = 8'(evStat);
          REG_MASK:   regRdata = 8'(evEn);
          REG_PTR:    regRdata = 8'(ptr);
          REG_STATUS: regRdata = {7'b0, busy};
          REG_LEVEL: begin
            regRdata[PTR_W-1:0] = lvlThr;
            regRdata[7]         = lvlDis;
          end
          default:    regRdata = '0;
        endcase
      end
      default: regRdata = '0;
    endcase
  end

endmodule

// File: tb/spi_tgt_buf_bench.sv
`timescale 1ns/1ps
module spi_tgt_buf_bench;

  localparam int D = 128;
  localparam logic [8:0] IB_BASE = 9'h100;
  localparam logic [8:0] OB_BASE = 9'h180;

  logic clk = 0, rst = 1, sck = 0, csN = 1, mosi = 0, regWe = 0;
  logic [8:0] regAddr = '0;
  logic [7:0] regWdata = '0, regRdata;
  logic miso, busy, irq;

  spi_tgt_buf u_spi_tgt_buf (
    .clk(clk), .rst(rst), .sck(sck), .csN(csN), .mosi(mosi), .miso(miso),
    .busy(busy), .irq(irq), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  always #2.5 clk = ~clk;

  int nTests = 0, nFail = 0;
  logic [7:0] ibM [D];
  logic [7:0] obM [D];
  int expPtr = 0, expCnt = 0, expThr = 8;
  bit expHeld = 0, expWrap = 0, expWrEn = 0, expDis = 0;
  logic [4:0] expEv = '0, expEn = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk); regWe = 0;
  endtask

  task automatic regRd(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdata;
  endtask

  task automatic setCfg(input bit en, input bit wrap, input bit wr);
    regWr(9'h000, {5'b0, wr, wrap, en});
    expWrap = wrap; expWrEn = wr;
    if (!en) begin expPtr = 0; expHeld = 0; expEv = '0; end
  endtask

  task automatic clrEv(input logic [4:0] m);
    regWr(9'h001, {3'b0, m});
    expEv = expEv & ~m;
  endtask

  task automatic xfer(input int n, input int seed, input string req);
    logic [7:0] tx, rxd, expOut;
    int bad = 0, badAct = 0, badExp = 0;
    @(negedge clk); csN = 0;
    repeat (10) @(negedge clk);
    expEv[0] = 1; expCnt = 0;
    for (int k = 0; k < n; k++) begin
      tx = 8'((seed + k * 37) & 255);
      expOut = obM[expPtr];
      for (int b = 7; b >= 0; b--) begin
        mosi = tx[b];
        repeat (8) @(negedge clk);
        rxd[b] = miso;
        sck = 1;
        repeat (8) @(negedge clk);
        sck = 0;
      end
      if (rxd !== expOut) begin
        if (bad == 0) begin badAct = rxd; badExp = expOut; end
        bad++;
      end
      if (!expHeld) begin
        if (expWrEn) ibM[expPtr] = tx;
        if (expPtr == 63) expEv[2] = 1;
        if (expPtr == D - 1) begin
          expEv[3] = 1;
          if (expWrap) expPtr = 0; else expHeld = 1;
        end else expPtr++;
      end
      if (expCnt < 127) begin
        expCnt++;
        if (!expDis && expThr != 0 && expCnt == expThr) expEv[4] = 1;
      end
    end
    repeat (8) @(negedge clk);
    csN = 1;
    repeat (10) @(negedge clk);
    expEv[1] = 1;
    chk(bad == 0, {req, " miso byte per position"}, badAct, badExp);
  endtask

  task automatic chkState(input string req);
    logic [7:0] d;
    regRd(9'h003, d); chk(d == 8'(expPtr), {req, " R12 pointer"}, d, expPtr);
    regRd(9'h001, d); chk(d == {3'b0, expEv}, {req, " events"}, d, expEv);
    #1; chk(irq == |(expEv & expEn), {req, " R8 irq"}, irq, |(expEv & expEn));
  endtask

  task automatic chkIbuf(input string req);
    logic [7:0] d;
    int bad = 0, bAct = 0, bExp = 0;
    for (int i = 0; i < D; i++) begin
      regRd(IB_BASE + 9'(i), d);
      if (d !== ibM[i]) begin
        if (bad == 0) begin bAct = d; bExp = ibM[i]; end
        bad++;
      end
    end
    chk(bad == 0, {req, " input buffer contents"}, bAct, bExp);
  endtask

  initial begin
    logic [7:0] d;
    int bad;
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (3) @(negedge clk);

    // Reset state
    regRd(9'h003, d); chk(d == 0, "R12 reset pointer", d, 0);
    regRd(9'h001, d); chk(d == 0, "R9 reset events", d, 0);
    regRd(9'h004, d); chk(d == 0, "R10 reset status", d, 0);
    regRd(9'h005, d); chk(d == 8'h08, "R6 default threshold", d, 8);
    chk(irq == 0, "R8 reset irq", irq, 0);

    // R1: stage both buffers and read back the output buffer
    for (int i = 0; i < D; i++) begin
      obM[i] = 8'((i * 7 + 3) & 255); ibM[i] = 8'h00;
      regWr(OB_BASE + 9'(i), obM[i]);
      regWr(IB_BASE + 9'(i), ibM[i]);
    end
    bad = 0;
    for (int i = 0; i < D; i++) begin
      regRd(OB_BASE + 9'(i), d);
      if (d !== obM[i]) bad++;
    end
    chk(bad == 0, "R1 output buffer readback", bad, 0);
    chkIbuf("R1");

    setCfg(1, 1, 1);
    regWr(9'h002, 8'h1F); expEn = 5'h1F;

    // Short transfer: R2 R3 R7
    xfer(3, 11, "R2 R3");
    chkState("R7 short");
    chkIbuf("R11 short");

    // R8 write-one-to-clear, one bit at a time
    clrEv(5'h01);
    regRd(9'h001, d); chk(d == {3'b0, expEv}, "R8 partial clear", d, expEv);
    clrEv(5'h02);
    regRd(9'h001, d); chk(d == 0, "R8 full clear", d, 0);
    #1; chk(irq == 0, "R8 irq low when clear", irq, 0);

    // R6 level event at exactly the threshold
    xfer(8, 50, "R6");
    chkState("R6 level at 8");
    clrEv(5'h1F);

    // R10 busy and R7 rise without SCK
    @(negedge clk); csN = 0; repeat (8) @(negedge clk);
    regRd(9'h004, d); chk(d == 1, "R10 busy while selected", d, 1);
    chk(busy == 1, "R10 busy pin", busy, 1);
    csN = 1; repeat (8) @(negedge clk);
    expEv = expEv | 5'h03;
    chkState("R7 no-clock transaction");
    clrEv(5'h1F);

    // R5 half crossing
    xfer(60, 99, "R5 half");
    chkState("R5 half");
    chkIbuf("R5 half");
    clrEv(5'h1F);

    // R4 R5 wrap past the end
    xfer(60, 7, "R4 wrap");
    chkState("R4 wrap full");
    chkIbuf("R4 wrap");
    clrEv(5'h1F);

    // R6 disable bit and another threshold
    regWr(9'h005, 8'h88); expDis = 1;
    xfer(10, 3, "R6 disabled");
    chkState("R6 disabled");
    clrEv(5'h1F);
    regWr(9'h005, 8'h05); expDis = 0; expThr = 5;
    xfer(4, 3, "R6 below");
    chkState("R6 below threshold");
    clrEv(5'h1F);
    xfer(5, 9, "R6 at 5");
    chkState("R6 threshold 5");
    clrEv(5'h1F);
    regWr(9'h005, 8'h08); expThr = 8;

    // R11 host writes blocked
    setCfg(1, 1, 0);
    xfer(4, 200, "R11");
    chkState("R11 ptr advances");
    chkIbuf("R11 no write");
    setCfg(1, 1, 1);

    // R8 mask
    regWr(9'h002, 8'h00); expEn = '0;
    #1; chk(irq == 0, "R8 masked irq", irq, 0);
    regWr(9'h002, 8'h1F); expEn = 5'h1F;
    #1; chk(irq == |expEv, "R8 unmasked irq", irq, |expEv);

    // R9 disable clears, serial ignored
    setCfg(0, 0, 0);
    chkState("R9 disabled");
    @(negedge clk); csN = 0; repeat (8) @(negedge clk);
    sck = 1; repeat (8) @(negedge clk); sck = 0; repeat (8) @(negedge clk);
    csN = 1; repeat (8) @(negedge clk);
    chkState("R9 serial ignored");

    // R4 no-wrap stop at the last entry
    setCfg(1, 0, 1);
    xfer(130, 17, "R4 stop");
    chkState("R4 stop at end");
    chkIbuf("R4 stop");

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule